// File: doc/BRIEF.md
# Serial Byte FIFO Pair with Threshold Interrupts

This block sits between a register bus and a serial shift engine. It holds one byte queue for outgoing data and one for incoming data. The bus writes bytes into the transmit queue and reads bytes from the receive queue. The engine takes bytes from the transmit queue and deposits received bytes into the receive queue. Both queue fill levels are visible in one packed level word.

The block watches three events: the receive queue has reached three quarters of its capacity, the transmit queue has drained to a quarter or less, and the engine has signalled the end of a transfer. Each event latches into a sticky status bit. Software clears a status bit by writing a one to it. A mask selects which status bits drive the single interrupt line. A control write can empty either queue on its own.

Top module: `serial_fifo_pair`

## Requirements
- R1: While rst_ni is low, both fill levels read zero, status_o is zero and irq_o is low.
- R2: Each queue holds 64 bytes and returns them in the order they were written. Bus writes enter the transmit queue and engine pops leave it. Engine pushes enter the receive queue and bus reads leave it.
- R3: levels_o carries the receive count in bits 6:0 and the transmit count in bits 22:16. Every other bit of levels_o is zero. Counts update one clock after the push or pop.
- R4: A push into a full queue is dropped. The count and the stored bytes stay the same.
- R5: While a queue is empty, its read data is zero. A pop from an empty queue leaves the count at zero.
- R6: Status bit 4 sets one clock after any cycle in which the receive count is 48 or more.
- R7: Status bit 12 sets one clock after any cycle in which the transmit count is 16 or less.
- R8: A one-cycle xfer_done_i pulse sets status bit 16. The bit stays set until it is cleared.
- R9: A cycle with sts_clr_i high clears every status bit that has a one in sts_clr_data_i. Writing all ones clears every bit. The clear wins for one cycle. If the event condition still holds, the bit sets again on the following clock.
- R10: A cycle with ctl_wr_i high and bit 8 of ctl_wdata_i set empties the transmit queue. Bit 9 empties the receive queue. Each flush leaves the other queue untouched and overrides any push or pop in the same cycle.
- R11: irq_o is high exactly when some status bit is set and its bit in irq_en_i is also set. The mask uses the same bit positions as the status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_wr_i | input | 1 | Bus write of one byte into the transmit queue |
| tx_wdata_i | input | 8 | Byte to write into the transmit queue |
| rx_rd_i | input | 1 | Bus read of one byte from the receive queue |
| rx_rdata_o | output | 8 | Head of the receive queue, or zero when it is empty |
| eng_tx_pop_i | input | 1 | Engine takes the transmit head |
| eng_tx_data_o | output | 8 | Head of the transmit queue, or zero when it is empty |
| eng_rx_push_i | input | 1 | Engine pushes a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| xfer_done_i | input | 1 | Transfer-complete pulse from the engine |
| ctl_wr_i | input | 1 | Control write strobe |
| ctl_wdata_i | input | 32 | Control data: bit 8 flushes transmit, bit 9 flushes receive |
| sts_clr_i | input | 1 | Status clear strobe |
| sts_clr_data_i | input | 32 | Write-one-to-clear mask for status |
| irq_en_i | input | 32 | Interrupt enable mask |
| status_o | output | 32 | Sticky status: bit 4 receive high, bit 12 transmit low, bit 16 done |
| levels_o | output | 32 | Fill levels: receive in 6:0, transmit in 22:16 |
| irq_o | output | 1 | Masked interrupt |

## Verification
On every cycle, the assertions check these rules: counts never exceed the depth; a push into a full queue is dropped; a pop from an empty queue reads zero and leaves the count alone; each threshold flag latches one clock after its condition; a cleared bit drops; a flush empties its queue. Some behaviours only the bench scenarios can show. These are byte ordering through a full wrap of each queue and a bit that sets again after being cleared while its level still holds. Two more are a flush that leaves the other queue intact and the interrupt following changes in the enable mask.

// File: rtl/serial_fifo_pkg.sv
package serial_fifo_pkg;
  localparam int unsigned RegW       = 32;
  localparam int unsigned RxHiBit    = 4;
  localparam int unsigned TxLoBit    = 12;
  localparam int unsigned DoneBit    = 16;
  localparam int unsigned TxFlushBit = 8;
  localparam int unsigned RxFlushBit = 9;
  localparam int unsigned RxCntLsb   = 0;
  localparam int unsigned TxCntLsb   = 16;
  localparam logic [RegW-1:0] StsImpl =
      (RegW'(1) << RxHiBit) | (RegW'(1) << TxLoBit) | (RegW'(1) << DoneBit);
endpackage

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int unsigned Depth = 64,
  parameter int unsigned Width = 8,
  localparam int unsigned AW = $clog2(Depth),
  localparam int unsigned CW = AW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [Width-1:0] wdata_i,
  input  logic             pop_i,
  output logic [Width-1:0] rdata_o,
  output logic [CW-1:0]    cnt_o
);
  logic [Width-1:0] mem_q [Depth];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    cnt_q;
  logic             full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(Depth));
  assign empty   = (cnt_q == '0);
  assign do_push = push_i && !full && !flush_i;
  assign do_pop  = pop_i && !empty && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + AW'(1);
      if (do_pop)  rd_ptr_q <= rd_ptr_q + AW'(1);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  assign rdata_o = empty ? '0 : mem_q[rd_ptr_q];
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/sticky_status.sv
module sticky_status #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] Impl = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] event_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_mask_i,
  input  logic [W-1:0] en_i,
  output logic [W-1:0] sts_o,
  output logic         irq_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    if (Impl[b]) begin : g_impl
      logic q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     q <= 1'b0;
        else if (clr_i && clr_mask_i[b]) q <= 1'b0;  // clear wins this cycle
        else if (event_i[b])             q <= 1'b1;
      end
      assign sts_o[b] = q;
    end else begin : g_tie
      assign sts_o[b] = 1'b0;
    end
  end

  assign irq_o = |(sts_o & en_i);
endmodule

// File: rtl/serial_fifo_pair.sv
module serial_fifo_pair
  import serial_fifo_pkg::*;
#(
  parameter int unsigned Depth = 64,
  localparam int unsigned CW   = $clog2(Depth) + 1,
  localparam int unsigned HiLvl = (Depth * 3) / 4,
  localparam int unsigned LoLvl = Depth / 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tx_wr_i,
  input  logic [7:0]      tx_wdata_i,
  input  logic            rx_rd_i,
  output logic [7:0]      rx_rdata_o,
  input  logic            eng_tx_pop_i,
  output logic [7:0]      eng_tx_data_o,
  input  logic            eng_rx_push_i,
  input  logic [7:0]      eng_rx_data_i,
  input  logic            xfer_done_i,
  input  logic            ctl_wr_i,
  input  logic [RegW-1:0] ctl_wdata_i,
  input  logic            sts_clr_i,
  input  logic [RegW-1:0] sts_clr_data_i,
  input  logic [RegW-1:0] irq_en_i,
  output logic [RegW-1:0] status_o,
  output logic [RegW-1:0] levels_o,
  output logic            irq_o
);
  logic [CW-1:0]   tx_cnt, rx_cnt;
  logic [RegW-1:0] events;

  byte_fifo #(.Depth(Depth), .Width(8)) u_tx_fifo (
    .clk_i, .rst_ni,
    .flush_i (ctl_wr_i && ctl_wdata_i[TxFlushBit]),
    .push_i  (tx_wr_i),
    .wdata_i (tx_wdata_i),
    .pop_i   (eng_tx_pop_i),
    .rdata_o (eng_tx_data_o),
    .cnt_o   (tx_cnt)
  );

  byte_fifo #(.Depth(Depth), .Width(8)) u_rx_fifo (
    .clk_i, .rst_ni,
    .flush_i (ctl_wr_i && ctl_wdata_i[RxFlushBit]),
    .push_i  (eng_rx_push_i),
    .wdata_i (eng_rx_data_i),
    .pop_i   (rx_rd_i),
    .rdata_o (rx_rdata_o),
    .cnt_o   (rx_cnt)
  );

  always_comb begin
    events          = '0;
    events[RxHiBit] = (rx_cnt >= CW'(HiLvl));
    events[TxLoBit] = (tx_cnt <= CW'(LoLvl));
    events[DoneBit] = xfer_done_i;
  end

  sticky_status #(.W(RegW), .Impl(StsImpl)) u_status (
    .clk_i, .rst_ni,
    .event_i    (events),
    .clr_i      (sts_clr_i),
    .clr_mask_i (sts_clr_data_i),
    .en_i       (irq_en_i),
    .sts_o      (status_o),
    .irq_o      (irq_o)
  );

  always_comb begin
    levels_o = '0;
    levels_o[RxCntLsb +: CW] = rx_cnt;
    levels_o[TxCntLsb +: CW] = tx_cnt;
  end
endmodule

// File: rtl/serial_fifo_pair_chk.sv
module serial_fifo_pair_chk #(
  parameter int unsigned Depth = 64
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        tx_wr_i,
  input logic        rx_rd_i,
  input logic        eng_tx_pop_i,
  input logic        eng_rx_push_i,
  input logic        ctl_wr_i,
  input logic [31:0] ctl_wdata_i,
  input logic        sts_clr_i,
  input logic [31:0] sts_clr_data_i,
  input logic [7:0]  eng_tx_data_o,
  input logic [7:0]  rx_rdata_o,
  input logic [31:0] status_o,
  input logic [31:0] levels_o
);
  logic [6:0] rx_l, tx_l;
  logic       tx_fl, rx_fl;
  assign rx_l  = levels_o[6:0];
  assign tx_l  = levels_o[22:16];
  assign tx_fl = ctl_wr_i && ctl_wdata_i[8];
  assign rx_fl = ctl_wr_i && ctl_wdata_i[9];

  AST_LEVEL_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(rx_l) <= Depth) && (32'(tx_l) <= Depth)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(tx_l) == Depth && tx_wr_i && !eng_tx_pop_i && !tx_fl) |=> (32'(tx_l) == Depth)); // R4
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_l == 0) |-> (rx_rdata_o == 8'h00)); // R5
  AST_EMPTY_POP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_l == 0 && eng_tx_pop_i && !tx_wr_i) |=> (tx_l == 0)); // R5
  AST_RX_HI_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_l >= 7'd48 && !(sts_clr_i && sts_clr_data_i[4])) |=> status_o[4]); // R6
  AST_TX_LO_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_l <= 7'd16 && !(sts_clr_i && sts_clr_data_i[12])) |=> status_o[12]); // R7
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sts_clr_i && sts_clr_data_i[16]) |=> !status_o[16]); // R9
  AST_TX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_fl |=> (tx_l == 0)); // R10
  AST_RX_FLUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_fl |=> (rx_l == 0)); // R10
endmodule

bind serial_fifo_pair serial_fifo_pair_chk #(.Depth(Depth)) u_chk (
  .clk_i, .rst_ni, .tx_wr_i, .rx_rd_i, .eng_tx_pop_i, .eng_rx_push_i,
  .ctl_wr_i, .ctl_wdata_i, .sts_clr_i, .sts_clr_data_i,
  .eng_tx_data_o, .rx_rdata_o, .status_o, .levels_o
);

// File: tb/serial_fifo_pair_tb.sv
module serial_fifo_pair_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tx_wr = 0, rx_rd = 0, tx_pop = 0, rx_push = 0, done = 0;
  logic        ctl_wr = 0, clr = 0;
  logic [7:0]  tx_wd = 0, rx_wd = 0;
  logic [31:0] ctl_wd = 0, clr_wd = 0, en = 0;
  logic [7:0]  rx_rdata, tx_data;
  logic [31:0] status, levels;
  logic        irq;

  int vectors = 0, miscompares = 0;
  bit timed_out = 0;

  byte unsigned txq[$], rxq[$];
  logic [31:0] m_sts = 0;

  always #2 clk = ~clk;

  serial_fifo_pair dut_i (
    .clk_i(clk), .rst_ni, .tx_wr_i(tx_wr), .tx_wdata_i(tx_wd), .rx_rd_i(rx_rd),
    .rx_rdata_o(rx_rdata), .eng_tx_pop_i(tx_pop), .eng_tx_data_o(tx_data),
    .eng_rx_push_i(rx_push), .eng_rx_data_i(rx_wd), .xfer_done_i(done),
    .ctl_wr_i(ctl_wr), .ctl_wdata_i(ctl_wd), .sts_clr_i(clr), .sts_clr_data_i(clr_wd),
    .irq_en_i(en), .status_o(status), .levels_o(levels), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FIFO_CHECK FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare all outputs with the model's pre-edge state
  task automatic compare(input string tag);
    logic [31:0] exp_lv;
    logic [7:0]  exp_tx, exp_rx;
    exp_lv = (32'(rxq.size()) & 32'h7f) | ((32'(txq.size()) & 32'h7f) << 16);
    exp_tx = (txq.size() == 0) ? 8'h00 : txq[0];
    exp_rx = (rxq.size() == 0) ? 8'h00 : rxq[0];
    chk(levels === exp_lv, {"R3 levels ", tag}, levels, exp_lv);
    chk(tx_data === exp_tx, {"R2/R5 tx head ", tag}, 32'(tx_data), 32'(exp_tx));
    chk(rx_rdata === exp_rx, {"R2/R5 rx head ", tag}, 32'(rx_rdata), 32'(exp_rx));
    chk(status === m_sts, {"R6/R7/R8/R9 status ", tag}, status, m_sts);
    chk(irq === |(m_sts & en), {"R11 irq ", tag}, 32'(irq), 32'(|(m_sts & en)));
  endtask

  // advance the model by one clock edge
  task automatic model_edge();
    logic [31:0] nxt;
    bit rx_hi, tx_lo;
    int n_tx, n_rx;
    n_tx  = txq.size();
    n_rx  = rxq.size();
    rx_hi = (n_rx >= 48);
    tx_lo = (n_tx <= 16);
    if (ctl_wr && ctl_wd[8]) txq.delete();
    else begin
      if (tx_pop && n_tx > 0) void'(txq.pop_front());
      if (tx_wr && n_tx < 64) txq.push_back(tx_wd);
    end
    if (ctl_wr && ctl_wd[9]) rxq.delete();
    else begin
      if (rx_rd && n_rx > 0) void'(rxq.pop_front());
      if (rx_push && n_rx < 64) rxq.push_back(rx_wd);
    end
    nxt = m_sts;
    nxt[4]  = (clr && clr_wd[4])  ? 1'b0 : (m_sts[4]  | rx_hi);
    nxt[12] = (clr && clr_wd[12]) ? 1'b0 : (m_sts[12] | tx_lo);
    nxt[16] = (clr && clr_wd[16]) ? 1'b0 : (m_sts[16] | done);
    m_sts = nxt;
  endtask

  // inputs are already driven after a negedge; check then step model
  task automatic cycle(input string tag);
    #1;
    compare(tag);
    model_edge();
    @(negedge clk);
  endtask

  task automatic idle();
    tx_wr = 0; rx_rd = 0; tx_pop = 0; rx_push = 0; done = 0; ctl_wr = 0; clr = 0;
    ctl_wd = 0; clr_wd = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    timed_out = 1;
    miscompares++;
    vectors++;
    $display("FIFO_CHECK FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    @(negedge clk);
    #1;
    // R1 reset state
    chk(levels === 32'h0, "R1 levels in reset", levels, 0);
    chk(status === 32'h0, "R1 status in reset", status, 0);
    chk(irq === 1'b0, "R1 irq in reset", 32'(irq), 0);
    @(negedge clk);
    rst_ni = 1'b1;
    en = 32'h0001_1010;

    // R7 transmit low flag at empty, then R9 clear while held re-sets
    idle(); cycle("r7_after_reset");
    idle(); clr = 1; clr_wd = 32'hffff_ffff; cycle("r9_clear_all");
    idle(); cycle("r9_dropped");
    idle(); cycle("r9_set_again");

    // R2/R4 fill transmit queue past capacity
    for (int i = 0; i < 70; i++) begin
      idle(); tx_wr = 1; tx_wd = 8'(i * 7 + 3); cycle("r4_tx_fill");
    end
    // clear transmit low flag while level is high
    idle(); clr = 1; clr_wd = 32'h1000; cycle("r9_clear_tx_lo");
    idle(); cycle("r7_stays_clear");
    // drain: order check, and R5 pops past empty
    for (int i = 0; i < 68; i++) begin
      idle(); tx_pop = 1; cycle("r2_tx_drain");
    end

    // R6 receive fill to threshold and beyond, R4 overflow
    for (int i = 0; i < 66; i++) begin
      idle(); rx_push = 1; rx_wd = 8'(255 - i); cycle("r6_rx_fill");
    end
    idle(); clr = 1; clr_wd = 32'h10; cycle("r9_clear_rx_hi");
    idle(); cycle("r6_dropped");
    idle(); cycle("r6_set_again");

    // R10 independent flushes; put bytes into transmit first
    for (int i = 0; i < 5; i++) begin
      idle(); tx_wr = 1; tx_wd = 8'(i + 100); cycle("r10_prep");
    end
    idle(); ctl_wr = 1; ctl_wd = 32'h200; rx_push = 1; rx_wd = 8'h55; cycle("r10_rx_flush");
    idle(); cycle("r10_tx_kept");
    idle(); ctl_wr = 1; ctl_wd = 32'h100; tx_wr = 1; tx_wd = 8'h66; cycle("r10_tx_flush");
    idle(); cycle("r10_tx_empty");

    // R8 done pulse sticky, R11 mask changes
    idle(); done = 1; cycle("r8_done_pulse");
    idle(); en = 32'h0; cycle("r11_masked");
    idle(); en = 32'h0001_0000; cycle("r11_done_only");
    idle(); clr = 1; clr_wd = 32'h0001_0000; cycle("r8_clear");
    idle(); cycle("r8_cleared");

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      idle();
      tx_wr   = ($urandom % 3) != 0;  tx_wd = 8'($urandom);
      tx_pop  = ($urandom % 3) != 0;
      rx_push = ($urandom % 3) != 0;  rx_wd = 8'($urandom);
      rx_rd   = ($urandom % 3) != 0;
      done    = ($urandom % 50) == 0;
      if (($urandom % 97) == 0) begin ctl_wr = 1; ctl_wd = 32'($urandom % 4) << 8; end
      if (($urandom % 13) == 0) begin clr = 1; clr_wd = $urandom; end
      if (($urandom % 40) == 0) en = $urandom;
      cycle("mix_r2_r11");
    end

    if (!timed_out) begin
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule